// File: doc/BRIEF.md
# PLL Divider Code Search Engine

This unit finds the input-divider and feedback-divider codes for a clock multiplier. A reference frequency and a target VCO frequency, both whole MHz, arrive with a one-cycle start pulse. The unit then tries every input-divider code. For each code it forms a fixed-point ratio with a serial divider, one quotient bit per clock. It drops any code whose phase-detector ratio falls outside the allowed window. For each code that survives, it tries one feedback code per clock. Each candidate frequency is capped, and the unit keeps the pair whose frequency lies closest to the target.

The control is one enumerated state machine with seven states:
- `S_IDLE` waits for start.
- `S_DIV_LOAD` launches the division for the current n.
- `S_DIV_WAIT` holds until the quotient is ready.
- `S_WINDOW` tests the ratio.
- `S_SCAN` walks m, one code per clock.
- `S_NEXT_N` advances n or ends the search.
- `S_FINISH` publishes the result.

The transitions are:
- Start taken: `S_IDLE` to `S_DIV_LOAD`.
- Launch: `S_DIV_LOAD` to `S_DIV_WAIT`.
- Quotient ready: `S_DIV_WAIT` to `S_WINDOW`.
- Window pass: `S_WINDOW` to `S_SCAN`.
- Window fail: `S_WINDOW` to `S_NEXT_N`.
- Last m: `S_SCAN` to `S_NEXT_N`.
- More n: `S_NEXT_N` to `S_DIV_LOAD`.
- Last n: `S_NEXT_N` to `S_FINISH`.
- Publish: `S_FINISH` to `S_IDLE`.

The results reach the outputs and `done` is raised on the same edge.

Top module: `pll_div_search`

## Requirements
- R1: The input-divider code n is tried from 0 up to 15. Its division factor is n+1, and its scaled ratio is floor((ref_mhz*1000 + n) / (n+1)).
- R2: Any n whose scaled ratio is below 2000 or above 8000 is skipped, and none of its m codes is evaluated.
- R3: The feedback code m is tried from 62 up to 623, with multiplier m+2. The candidate frequency is floor(ratio*(m+2)/1000), and a candidate above 1250 is discarded. A reported solution therefore always has best_m within 62..623.
- R4: The error is |candidate - target_mhz|. The best pair is replaced only on a strictly smaller error, so the first pair in scan order (n ascending, then m ascending) wins a tie.
- R5: Each search starts from best error 3000 with n=0 and m=0. If no pair qualifies, the outputs are best_n=0, best_m=0, best_err=3000, and no_solution is 1 together with done. Otherwise no_solution is 0.
- R6: `done` is high for exactly one cycle per search. best_n, best_m, best_err and no_solution change only in that cycle and hold their values afterwards.
- R7: A start pulse that arrives while a search is running is ignored. The running search finishes with its own inputs, and no second search follows.
- R8: After reset, done, no_solution, best_n, best_m and best_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; sampled only while idle |
| ref_mhz | input | REF_W (6) | Reference clock in MHz |
| target_mhz | input | TGT_W (11) | Target VCO frequency in MHz |
| done | output | 1 | One-cycle completion pulse |
| no_solution | output | 1 | No pair qualified in the last search |
| best_n | output | 4 | Chosen input-divider code |
| best_m | output | 10 | Chosen feedback-divider code |
| best_err | output | ERR_W (12) | Absolute error of the chosen pair in MHz |

## Verification
The result has no fixed latency. It takes 16 divisions of about 17 cycles each, plus 562 scan cycles for each n that passes the window, so `done` can come anywhere from a few hundred to about ten thousand cycles after start. The bench drives start on a falling edge and polls `done` at each falling edge. It reads all results in the sample where `done` is first seen high. It then checks that `done` is low at the very next falling edge and that the outputs still hold tens of cycles later. Expected codes come from hand evaluation of the search rules.

// File: rtl/pds_pkg.sv
package pds_pkg;
    localparam int N_CODE_W = 4;
    localparam int N_LAST   = 15;
    localparam int M_CODE_W = 10;
    localparam int M_FIRST  = 62;
    localparam int M_LAST   = 623;
    localparam int M_OFFSET = 2;
    localparam int SCALE    = 1000;
    localparam int RATIO_LO = 2000;
    localparam int RATIO_HI = 8000;
    localparam int FVCO_CAP = 1250;
    localparam int ERR_INIT = 3000;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIV_LOAD,
        S_DIV_WAIT,
        S_WINDOW,
        S_SCAN,
        S_NEXT_N,
        S_FINISH
    } search_state_e;
endpackage

// File: rtl/pds_seq_div.sv
module pds_seq_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W:0]       rem_q;
    logic [W-1:0]     quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [W:0]       shifted;
    logic [W:0]       trial;

    always_comb begin
        shifted = {rem_q[W-1:0], quo_q[W-1]};
        trial   = shifted - {1'b0, divisor};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= dividend;
                cnt_q <= CNT_W'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!trial[W]) begin
                    rem_q <= trial;
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted;
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;
endmodule

// File: rtl/pds_cand_eval.sv
module pds_cand_eval
    import pds_pkg::*;
#(
    parameter int RATIO_W = 16,
    parameter int TGT_W   = 11,
    parameter int ERR_W   = 12
) (
    input  logic [RATIO_W-1:0]  ratio,
    input  logic [M_CODE_W-1:0] m_code,
    input  logic [TGT_W-1:0]    target,
    input  logic [ERR_W-1:0]    best_err,
    output logic                cand_ok,
    output logic [ERR_W-1:0]    cand_err,
    output logic                improves
);
    localparam int PROD_W = RATIO_W + M_CODE_W;

    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] vco;
    logic [ERR_W-1:0]  vco_small;
    logic [ERR_W-1:0]  tgt_ext;

    always_comb begin
        product   = PROD_W'(ratio) * PROD_W'(m_code + M_CODE_W'(M_OFFSET));
        vco       = product / PROD_W'(SCALE);
        cand_ok   = (vco <= PROD_W'(FVCO_CAP));
        vco_small = vco[ERR_W-1:0];
        tgt_ext   = ERR_W'(target);
        cand_err  = (vco_small >= tgt_ext) ? (vco_small - tgt_ext) : (tgt_ext - vco_small);
        improves  = cand_ok && (cand_err < best_err);
    end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pds_pkg::*;
#(
    parameter int REF_W = 6,
    parameter int TGT_W = 11,
    parameter int ERR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [REF_W-1:0]    ref_mhz,
    input  logic [TGT_W-1:0]    target_mhz,
    output logic                done,
    output logic                no_solution,
    output logic [N_CODE_W-1:0] best_n,
    output logic [M_CODE_W-1:0] best_m,
    output logic [ERR_W-1:0]    best_err
);
    localparam int DIVD_W = REF_W + 10;

    search_state_e       state_q, state_d;
    logic [REF_W-1:0]    ref_q;
    logic [TGT_W-1:0]    tgt_q;
    logic [N_CODE_W-1:0] n_q;
    logic [M_CODE_W-1:0] m_q;
    logic [DIVD_W-1:0]   ratio_q;
    logic [N_CODE_W-1:0] work_n;
    logic [M_CODE_W-1:0] work_m;
    logic [ERR_W-1:0]    work_err;
    logic                found_q;

    logic                div_go;
    logic                div_done;
    logic [DIVD_W-1:0]   div_quot;
    logic [DIVD_W-1:0]   dividend;
    logic [DIVD_W-1:0]   divisor;
    logic                in_window;
    logic                cand_ok;
    logic [ERR_W-1:0]    cand_err;
    logic                improves;

    always_comb begin
        div_go    = (state_q == S_DIV_LOAD);
        dividend  = DIVD_W'(ref_q) * DIVD_W'(SCALE) + DIVD_W'(n_q);
        divisor   = DIVD_W'(n_q) + DIVD_W'(1);
        in_window = (ratio_q >= DIVD_W'(RATIO_LO)) && (ratio_q <= DIVD_W'(RATIO_HI));
    end

    pds_seq_div #(.W(DIVD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (dividend),
        .divisor  (divisor),
        .done     (div_done),
        .quotient (div_quot)
    );

    pds_cand_eval #(.RATIO_W(DIVD_W), .TGT_W(TGT_W), .ERR_W(ERR_W)) u_eval (
        .ratio    (ratio_q),
        .m_code   (m_q),
        .target   (tgt_q),
        .best_err (work_err),
        .cand_ok  (cand_ok),
        .cand_err (cand_err),
        .improves (improves)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_DIV_LOAD;
            S_DIV_LOAD: state_d = S_DIV_WAIT;
            S_DIV_WAIT: if (div_done) state_d = S_WINDOW;
            S_WINDOW:   state_d = in_window ? S_SCAN : S_NEXT_N;
            S_SCAN:     if (m_q == M_CODE_W'(M_LAST)) state_d = S_NEXT_N;
            S_NEXT_N:   state_d = (n_q == N_CODE_W'(N_LAST)) ? S_FINISH : S_DIV_LOAD;
            S_FINISH:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q       <= '0;
            tgt_q       <= '0;
            n_q         <= '0;
            m_q         <= '0;
            ratio_q     <= '0;
            work_n      <= '0;
            work_m      <= '0;
            work_err    <= '0;
            found_q     <= 1'b0;
            done        <= 1'b0;
            no_solution <= 1'b0;
            best_n      <= '0;
            best_m      <= '0;
            best_err    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        ref_q    <= ref_mhz;
                        tgt_q    <= target_mhz;
                        n_q      <= '0;
                        work_n   <= '0;
                        work_m   <= '0;
                        work_err <= ERR_W'(ERR_INIT);
                        found_q  <= 1'b0;
                    end
                end
                S_DIV_LOAD: ;
                S_DIV_WAIT: begin
                    if (div_done) ratio_q <= div_quot;
                end
                S_WINDOW: begin
                    m_q <= M_CODE_W'(M_FIRST);
                end
                S_SCAN: begin
                    if (improves) begin
                        work_n   <= n_q;
                        work_m   <= m_q;
                        work_err <= cand_err;
                        found_q  <= 1'b1;
                    end
                    if (m_q != M_CODE_W'(M_LAST)) m_q <= m_q + 1'b1;
                end
                S_NEXT_N: begin
                    if (n_q != N_CODE_W'(N_LAST)) n_q <= n_q + 1'b1;
                end
                S_FINISH: begin
                    done        <= 1'b1;
                    no_solution <= !found_q;
                    best_n      <= work_n;
                    best_m      <= work_m;
                    best_err    <= work_err;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pds_checker.sv
module pds_checker
    import pds_pkg::*;
#(
    parameter int REF_W  = 6,
    parameter int TGT_W  = 11,
    parameter int ERR_W  = 12,
    parameter int DIVD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                done,
    input logic                no_solution,
    input logic [N_CODE_W-1:0] best_n,
    input logic [M_CODE_W-1:0] best_m,
    input logic [ERR_W-1:0]    best_err,
    input search_state_e       state,
    input logic [DIVD_W-1:0]   ratio,
    input logic [M_CODE_W-1:0] m_code,
    input logic [ERR_W-1:0]    work_err,
    input logic [REF_W-1:0]    ref_lat,
    input logic [TGT_W-1:0]    tgt_lat
);
    AST_WINDOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_SCAN |-> (ratio >= DIVD_W'(RATIO_LO) && ratio <= DIVD_W'(RATIO_HI))); // R2

    AST_M_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_SCAN |-> (m_code >= M_CODE_W'(M_FIRST) && m_code <= M_CODE_W'(M_LAST))); // R3

    AST_SOL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_solution) |-> (best_m >= M_CODE_W'(M_FIRST) && best_m <= M_CODE_W'(M_LAST)
                                    && best_err < ERR_W'(ERR_INIT))); // R3

    AST_ERR_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        state != S_IDLE |=> work_err <= $past(work_err)); // R4

    AST_NO_SOL_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_solution) |-> (best_n == '0 && best_m == '0 && best_err == ERR_W'(ERR_INIT))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(best_n) && $stable(best_m) && $stable(best_err) && $stable(no_solution))); // R6

    AST_INPUT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        state != S_IDLE |=> ($stable(ref_lat) && $stable(tgt_lat))); // R7
endmodule

bind pll_div_search pds_checker #(
    .REF_W(REF_W), .TGT_W(TGT_W), .ERR_W(ERR_W), .DIVD_W(REF_W + 10)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .no_solution (no_solution),
    .best_n      (best_n),
    .best_m      (best_m),
    .best_err    (best_err),
    .state       (state_q),
    .ratio       (ratio_q),
    .m_code      (m_q),
    .work_err    (work_err),
    .ref_lat     (ref_q),
    .tgt_lat     (tgt_q)
);

// File: tb/tb_pll_div_search.sv
module tb_pll_div_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  ref_mhz = '0;
    logic [10:0] target_mhz = '0;
    logic        done;
    logic        no_solution;
    logic [3:0]  best_n;
    logic [9:0]  best_m;
    logic [11:0] best_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pll_div_search dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_mhz(ref_mhz), .target_mhz(target_mhz),
        .done(done), .no_solution(no_solution), .best_n(best_n), .best_m(best_m), .best_err(best_err)
    );

    typedef struct packed {
        logic [5:0]  rf;
        logic [10:0] tg;
        logic [3:0]  en;
        logic [9:0]  em;
        logic [11:0] ee;
        logic        ens;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{6'd24, 11'd600,  4'd2,  10'd73,  12'd0,    1'b0}, // R1 R2: n=0,1 out of window
        '{6'd24, 11'd1249, 4'd2,  10'd154, 12'd1,    1'b0}, // R3 R4: 1250 ties later
        '{6'd24, 11'd100,  4'd11, 10'd62,  12'd28,   1'b0}, // R2: last n in window wins
        '{6'd2,  11'd1000, 4'd0,  10'd498, 12'd0,    1'b0}, // R1
        '{6'd2,  11'd2000, 4'd0,  10'd623, 12'd750,  1'b0}, // R3: cap at 1250, m upper end
        '{6'd2,  11'd0,    4'd0,  10'd62,  12'd128,  1'b0}, // R3: m lower end
        '{6'd8,  11'd1000, 4'd0,  10'd123, 12'd0,    1'b0}, // R4: tie with n=1 kept first
        '{6'd8,  11'd0,    4'd3,  10'd62,  12'd128,  1'b0}, // R1: rounding offset keeps n=3
        '{6'd63, 11'd1250, 4'd12, 10'd256, 12'd0,    1'b0}, // R2
        '{6'd1,  11'd500,  4'd0,  10'd0,   12'd3000, 1'b1}  // R5: no n in window
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic pulse_start(input logic [5:0] r, input logic [10:0] t);
        @(negedge clk);
        ref_mhz = r;
        target_mhz = t;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag, output bit got);
        got = 1'b0;
        for (int i = 0; i < 20000 && !got; i++) begin
            if (done) got = 1'b1;
            else @(negedge clk);
        end
        checks++;
        if (!got) begin
            errors++;
            $display("FAIL %s done: actual 0 expected 1 (timeout)", tag);
        end
    endtask

    task automatic check_result(input string tag, input vec_t v);
        chk(tag, "best_n", int'(best_n), int'(v.en));
        chk(tag, "best_m", int'(best_m), int'(v.em));
        chk(tag, "best_err", int'(best_err), int'(v.ee));
        chk(tag, "no_solution", int'(no_solution), int'(v.ens));
    endtask

    initial begin
        #(1900000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        bit got;
        vec_t busy_v;
        int quiet;

        // R8 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "done", int'(done), 0);
        chk("R8", "no_solution", int'(no_solution), 0);
        chk("R8", "best_n", int'(best_n), 0);
        chk("R8", "best_m", int'(best_m), 0);
        chk("R8", "best_err", int'(best_err), 0);

        // vector table
        for (int k = 0; k < NV; k++) begin
            pulse_start(VECS[k].rf, VECS[k].tg);
            wait_done("R1 R2 R3 R4 R5", got);
            if (got) begin
                check_result("R1 R2 R3 R4 R5", VECS[k]);
                @(negedge clk);
                chk("R6", "done second cycle", int'(done), 0);
            end
        end

        // R5: zero reference also has no solution
        pulse_start(6'd0, 11'd300);
        wait_done("R5", got);
        if (got) check_result("R5", '{6'd0, 11'd300, 4'd0, 10'd0, 12'd3000, 1'b1});

        // R7: start during a search is ignored
        busy_v = '{6'd24, 11'd600, 4'd2, 10'd73, 12'd0, 1'b0};
        pulse_start(6'd24, 11'd600);
        repeat (40) @(negedge clk);
        pulse_start(6'd2, 11'd1000);
        wait_done("R7", got);
        if (got) begin
            check_result("R7", busy_v);
            // R6 and R7: no second pulse, outputs held
            quiet = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (done) quiet++;
            end
            chk("R7", "extra done pulses", quiet, 0);
            check_result("R6", busy_v);
        end

        // R8: reset after a completed search clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "best_m after reset", int'(best_m), 0);
        chk("R8", "best_n after reset", int'(best_n), 0);

        summary();
    end
endmodule